// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block brings the analog front end of a serial video transmitter out of reset without software help. After a start pulse it clears a 32-bit analog control word. It then switches on the bias, clocking, regulator and calibration enables one at a time, in a fixed order. Between the steps that need settling time it waits a set number of microseconds.

Each wait counts pulses of an external microsecond tick, so the dwell times do not depend on the system clock frequency. The data-lane serializers come up in two stages. The first stage comes before a poll of the resistance-calibration done flag, and the second comes after it. The poll gives up after a bounded number of ticks, raises a sticky timeout flag and lets the sequence finish anyway. At the end the 6-bit calibration result is captured, and a one-cycle done pulse tells the surrounding logic that the code is valid.

Top module: `phy_pwrup_seq`

## Requirements
- R1: While reset is asserted, `ana_ctrl`, `cal_code`, `seq_done` and `cal_timeout` are all zero.
- R2: A start pulse seen while idle makes the next register update clear all 32 bits of `ana_ctrl`. The update after that sets bit 0 (bias), and the sequence then waits 5 ticks.
- R3: The next steps set, in order: bit 16 (transmit clock), with no wait; bit 1 (voltage reference), then a 20-tick wait; bit 2 (regulator), then a 5-tick wait; bit 3 (common clock), then a 100-tick wait. Each step changes `ana_ctrl` one clock after the previous step's wait ends.
- R4: Bit 19 (calibration analog) is set and followed by a 200-tick wait. Bit 18 (calibration digital) is then set, and one clock later the serializer field, bits 7:4, is loaded with 0x7 (data lanes only).
- R5: During the poll, `cal_done` is sampled only on cycles with `us_tick` high. The first such cycle on which it is high ends the poll.
- R6: If `cal_done` is low on 2000 consecutive polled ticks, `cal_timeout` goes high and the sequence carries on. `cal_timeout` stays high until the next accepted start, which clears it.
- R7: After the poll, bits 11:8 (current/voltage bias) become 0xF. One clock later bits 7:4 become 0xF. The final control word is 0x000D0FFF.
- R8: One clock after the last control write, `cal_val` is latched into `cal_code`, and `seq_done` is high for exactly one cycle, in the cycle that follows the latch.
- R9: A start pulse that arrives while a sequence is in progress has no effect on `ana_ctrl`, on the timing, or on the number of done pulses.
- R10: Clock cycles without `us_tick` do not advance any wait or poll count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Single-cycle request to run the power-up sequence |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cal_done | input | 1 | Resistance-calibration finished flag from the analog block |
| cal_val | input | 6 | Resistance-calibration result from the analog block |
| ana_ctrl | output | 32 | Analog control register contents |
| cal_code | output | 6 | Captured calibration code |
| seq_done | output | 1 | One-cycle pulse when the sequence is complete |
| cal_timeout | output | 1 | Sticky flag: calibration never signalled done during the poll |

## Verification
The assertions assume that `us_tick` is a clean pulse and that `cal_done` and `cal_val` are already synchronous to `clk`. The stimulus therefore changes every input only on the falling clock edge, and the tick is generated on a fixed period.

The runs use ticks on every cycle and ticks on every third cycle. The calibration flag is driven three ways: high from the start, raised partway through the poll, and never raised. Extra start pulses are issued both during a wait and during the poll, to show that they are ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int CTRL_W   = 32;
  localparam int CODE_W   = 6;

  // control word field positions (decoded by the analog front end)
  localparam int BIT_BIAS = 0;
  localparam int BIT_VREF = 1;
  localparam int BIT_LDO  = 2;
  localparam int BIT_CKEN = 3;
  localparam int SER_LSB  = 4;
  localparam int SER_W    = 4;
  localparam int CUR_LSB  = 8;
  localparam int CUR_W    = 4;
  localparam int BIT_TCLK = 16;
  localparam int BIT_CALD = 18;
  localparam int BIT_CALA = 19;

  localparam logic [SER_W-1:0] SER_DATA = 4'h7;
  localparam logic [SER_W-1:0] SER_ALL  = 4'hF;
  localparam logic [CUR_W-1:0] CUR_ALL  = 4'hF;

  typedef enum logic [3:0] {
    STP_CLEAR,
    STP_BIAS,
    STP_TCLK,
    STP_VREF,
    STP_LDO,
    STP_CKEN,
    STP_CALA,
    STP_CALD,
    STP_SER_DATA,
    STP_CUR,
    STP_SER_ALL
  } step_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_APPLY,
    ST_WAIT,
    ST_POLL,
    ST_FINISH
  } seq_state_e;

  function automatic logic [CTRL_W-1:0] step_apply(step_e s, logic [CTRL_W-1:0] cur);
    logic [CTRL_W-1:0] r;
    r = cur;
    case (s)
      STP_CLEAR:    r = '0;
      STP_BIAS:     r[BIT_BIAS] = 1'b1;
      STP_TCLK:     r[BIT_TCLK] = 1'b1;
      STP_VREF:     r[BIT_VREF] = 1'b1;
      STP_LDO:      r[BIT_LDO]  = 1'b1;
      STP_CKEN:     r[BIT_CKEN] = 1'b1;
      STP_CALA:     r[BIT_CALA] = 1'b1;
      STP_CALD:     r[BIT_CALD] = 1'b1;
      STP_SER_DATA: r[SER_LSB +: SER_W] = SER_DATA;
      STP_CUR:      r[CUR_LSB +: CUR_W] = CUR_ALL;
      STP_SER_ALL:  r[SER_LSB +: SER_W] = SER_ALL;
      default:      r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwrseq_rst_sync.sv
module pwrseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr) begin
      cnt_n = '0;
    end else if (en) begin
      cnt_n = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign expire = en && (cnt_q == (limit - CNT_W'(1)));

  // R10
  cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < limit));

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int DW_BIAS  = 5,
  parameter int DW_VREF  = 20,
  parameter int DW_LDO   = 5,
  parameter int DW_CKEN  = 100,
  parameter int DW_CALA  = 200,
  parameter int POLL_MAX = 2000,
  parameter int CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              us_tick,
  input  logic              cal_done,
  input  logic [CODE_W-1:0] cal_val,
  input  logic              tmr_expire,
  output logic              tmr_clr,
  output logic              tmr_en,
  output logic [CNT_W-1:0]  tmr_limit,
  output logic [CTRL_W-1:0] ana_ctrl,
  output logic [CODE_W-1:0] cal_code,
  output logic              seq_done,
  output logic              cal_timeout
);

  seq_state_e        state_q, state_n;
  step_e             step_q, step_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              done_q, done_n;
  logic              tmo_q, tmo_n;
  logic              advance;

  function automatic logic [CNT_W-1:0] dwell_of(step_e s);
    case (s)
      STP_BIAS: return CNT_W'(DW_BIAS);
      STP_VREF: return CNT_W'(DW_VREF);
      STP_LDO:  return CNT_W'(DW_LDO);
      STP_CKEN: return CNT_W'(DW_CKEN);
      STP_CALA: return CNT_W'(DW_CALA);
      default:  return '0;
    endcase
  endfunction

  always_comb begin
    state_n   = state_q;
    step_n    = step_q;
    ctrl_n    = ctrl_q;
    code_n    = code_q;
    tmo_n     = tmo_q;
    done_n    = 1'b0;
    tmr_clr   = 1'b0;
    tmr_en    = 1'b0;
    tmr_limit = dwell_of(step_q);
    advance   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_APPLY;
          step_n  = STP_CLEAR;
          tmo_n   = 1'b0;
        end
      end
      ST_APPLY: begin
        ctrl_n = step_apply(step_q, ctrl_q);
        if (dwell_of(step_q) == '0) begin
          advance = 1'b1;
        end else begin
          state_n = ST_WAIT;
          tmr_clr = 1'b1;
        end
      end
      ST_WAIT: begin
        tmr_en = us_tick;
        if (tmr_expire) begin
          advance = 1'b1;
        end
      end
      ST_POLL: begin
        tmr_limit = CNT_W'(POLL_MAX);
        tmr_en    = us_tick && !cal_done;
        if (us_tick && cal_done) begin
          state_n = ST_APPLY;
          step_n  = STP_CUR;
        end else if (tmr_expire) begin
          tmo_n   = 1'b1;
          state_n = ST_APPLY;
          step_n  = STP_CUR;
        end
      end
      ST_FINISH: begin
        code_n  = cal_val;
        done_n  = 1'b1;
        state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase

    if (advance) begin
      if (step_q == STP_SER_DATA) begin
        state_n = ST_POLL;
        tmr_clr = 1'b1;
      end else if (step_q == STP_SER_ALL) begin
        state_n = ST_FINISH;
      end else begin
        state_n = ST_APPLY;
        step_n  = step_e'(4'(step_q) + 4'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= STP_CLEAR;
      ctrl_q  <= '0;
      code_q  <= '0;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      step_q  <= step_n;
      ctrl_q  <= ctrl_n;
      code_q  <= code_n;
      done_q  <= done_n;
      tmo_q   <= tmo_n;
    end
  end

  assign ana_ctrl    = ctrl_q;
  assign cal_code    = code_q;
  assign seq_done    = done_q;
  assign cal_timeout = tmo_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_APPLY) |=> $stable(ctrl_q));

  // R3
  enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[BIT_CKEN] |-> (ctrl_q[BIT_LDO] && ctrl_q[BIT_VREF] &&
                          ctrl_q[BIT_BIAS] && ctrl_q[BIT_TCLK]));

  // R4
  cal_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[BIT_CALD] |-> ctrl_q[BIT_CALA]);

  // R7
  clock_lane_after_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[SER_LSB +: SER_W] == SER_ALL) |-> (ctrl_q[CUR_LSB +: CUR_W] == CUR_ALL));

  // R6
  timeout_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> ($past(state_q) == ST_POLL));

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import pwrseq_pkg::*;
#(
  parameter int DW_BIAS  = 5,
  parameter int DW_VREF  = 20,
  parameter int DW_LDO   = 5,
  parameter int DW_CKEN  = 100,
  parameter int DW_CALA  = 200,
  parameter int POLL_MAX = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        us_tick,
  input  logic        cal_done,
  input  logic [5:0]  cal_val,
  output logic [31:0] ana_ctrl,
  output logic [5:0]  cal_code,
  output logic        seq_done,
  output logic        cal_timeout
);

  localparam int MAX_A   = (DW_BIAS > DW_VREF) ? DW_BIAS : DW_VREF;
  localparam int MAX_B   = (DW_LDO > DW_CKEN) ? DW_LDO : DW_CKEN;
  localparam int MAX_C   = (DW_CALA > POLL_MAX) ? DW_CALA : POLL_MAX;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int LIM_MAX = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic             rst_n_s;
  logic             tmr_clr;
  logic             tmr_en;
  logic             tmr_expire;
  logic [CNT_W-1:0] tmr_limit;

  pwrseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (tmr_clr),
    .en     (tmr_en),
    .limit  (tmr_limit),
    .expire (tmr_expire)
  );

  pwrseq_fsm #(
    .DW_BIAS  (DW_BIAS),
    .DW_VREF  (DW_VREF),
    .DW_LDO   (DW_LDO),
    .DW_CKEN  (DW_CKEN),
    .DW_CALA  (DW_CALA),
    .POLL_MAX (POLL_MAX),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start       (start),
    .us_tick     (us_tick),
    .cal_done    (cal_done),
    .cal_val     (cal_val),
    .tmr_expire  (tmr_expire),
    .tmr_clr     (tmr_clr),
    .tmr_en      (tmr_en),
    .tmr_limit   (tmr_limit),
    .ana_ctrl    (ana_ctrl),
    .cal_code    (cal_code),
    .seq_done    (seq_done),
    .cal_timeout (cal_timeout)
  );

endmodule

// File: tb/phy_pwrup_seq_bench.sv
`timescale 1ns/1ps
module phy_pwrup_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        us_tick;
  logic        cal_done;
  logic [5:0]  cal_val;
  logic [31:0] ana_ctrl;
  logic [5:0]  cal_code;
  logic        seq_done;
  logic        cal_timeout;

  phy_pwrup_seq u_phy_pwrup_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .us_tick     (us_tick),
    .cal_done    (cal_done),
    .cal_val     (cal_val),
    .ana_ctrl    (ana_ctrl),
    .cal_code    (cal_code),
    .seq_done    (seq_done),
    .cal_timeout (cal_timeout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit wd_hit = 0;
  bit cmp_on = 0;

  // tick generator
  int tick_per = 1;
  int tick_ctr = 0;
  always @(negedge clk) begin
    tick_ctr++;
    us_tick = ((tick_ctr % tick_per) == 0);
  end

  // ---------------- behavioural reference ----------------
  int          q_kind[$];
  logic [31:0] q_clr[$];
  logic [31:0] q_set[$];
  int          q_dw[$];
  string       q_tag[$];

  int          m_mode;   // 0 idle, 1 apply, 2 wait, 3 poll, 4 finish
  logic [31:0] m_ctrl;
  logic [5:0]  m_code;
  bit          m_done;
  bit          m_tmo;
  int          m_rem;
  int          m_polls;
  string       m_tag;
  string       tag_pfx = "";

  task automatic push_op(int k, logic [31:0] c, logic [31:0] s, int d, string t);
    q_kind.push_back(k);
    q_clr.push_back(c);
    q_set.push_back(s);
    q_dw.push_back(d);
    q_tag.push_back(t);
  endtask

  task automatic load_ops();
    q_kind.delete(); q_clr.delete(); q_set.delete(); q_dw.delete(); q_tag.delete();
    push_op(0, 32'hFFFF_FFFF, 32'h0, 0, "R2");
    push_op(0, 32'h0, 32'h1 << 0, 5, "R2");
    push_op(0, 32'h0, 32'h1 << 16, 0, "R3");
    push_op(0, 32'h0, 32'h1 << 1, 20, "R3");
    push_op(0, 32'h0, 32'h1 << 2, 5, "R3");
    push_op(0, 32'h0, 32'h1 << 3, 100, "R3");
    push_op(0, 32'h0, 32'h1 << 19, 200, "R4");
    push_op(0, 32'h0, 32'h1 << 18, 0, "R4");
    push_op(0, 32'h0000_00F0, 32'h0000_0070, 0, "R4");
    push_op(1, 32'h0, 32'h0, 0, "R5");
    push_op(0, 32'h0000_0F00, 32'h0000_0F00, 0, "R7");
    push_op(0, 32'h0000_00F0, 32'h0000_00F0, 0, "R7");
  endtask

  task automatic follow();
    if (q_kind.size() == 0) begin
      m_mode = 4;
    end else if (q_kind[0] == 1) begin
      m_tag = q_tag.pop_front();
      void'(q_kind.pop_front()); void'(q_clr.pop_front());
      void'(q_set.pop_front()); void'(q_dw.pop_front());
      m_mode = 3;
      m_polls = 0;
    end else begin
      m_mode = 1;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd_hit = 1;
    if (!rst_n) begin
      m_mode = 0; m_ctrl = '0; m_code = '0; m_done = 0; m_tmo = 0;
      m_rem = 0; m_polls = 0; m_tag = "R1";
    end else begin
      m_done = 0;
      case (m_mode)
        0: if (start) begin load_ops(); m_tmo = 0; m_mode = 1; end
        1: begin
          logic [31:0] c, s;
          int d;
          c = q_clr.pop_front();
          s = q_set.pop_front();
          d = q_dw.pop_front();
          m_tag = q_tag.pop_front();
          void'(q_kind.pop_front());
          m_ctrl = (m_ctrl & ~c) | s;
          if (d == 0) follow();
          else begin m_mode = 2; m_rem = d; end
        end
        2: if (us_tick) begin
          m_rem--;
          if (m_rem == 0) follow();
        end
        3: if (us_tick) begin
          if (cal_done) follow();
          else begin
            m_polls++;
            if (m_polls == 2000) begin m_tmo = 1; m_tag = "R6"; follow(); end
          end
        end
        4: begin m_code = cal_val; m_done = 1; m_mode = 0; end
        default: m_mode = 0;
      endcase
    end
  end

  // ---------------- per-cycle comparison ----------------
  int done_cnt;
  always @(negedge clk) begin
    if (cmp_on) begin
      bit bad;
      bad = 0;
      n_cmp++;
      if (ana_ctrl !== m_ctrl) begin
        bad = 1;
        $display("FAIL %s%s ana_ctrl act=%h exp=%h t=%0t", tag_pfx, m_tag, ana_ctrl, m_ctrl, $time);
      end
      if (cal_code !== m_code) begin
        bad = 1;
        $display("FAIL R8 cal_code act=%h exp=%h t=%0t", cal_code, m_code, $time);
      end
      if (seq_done !== m_done) begin
        bad = 1;
        $display("FAIL R8 seq_done act=%b exp=%b t=%0t", seq_done, m_done, $time);
      end
      if (cal_timeout !== m_tmo) begin
        bad = 1;
        $display("FAIL R6 cal_timeout act=%b exp=%b t=%0t", cal_timeout, m_tmo, $time);
      end
      if (bad) n_bad++;
      if (seq_done === 1'b1) done_cnt++;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run_seq(int per, int raise_after, logic [5:0] val, bit poke, bit exp_tmo);
    int n;
    int pc;
    tick_per = per;
    cal_val  = val;
    cal_done = (raise_after == 0);
    done_cnt = 0;
    n = 0;
    pc = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (done_cnt == 0 && !wd_hit) begin
      @(negedge clk);
      n++;
      if (n == 2) chk(cal_timeout == 1'b0, "R6", 32'(cal_timeout), 32'h0, "flag cleared by start");
      if (m_mode == 3) pc++;
      start = poke && (n == 40 || pc == 10);   // R9 extra starts while busy
      if (raise_after > 0 && pc >= raise_after) cal_done = 1'b1;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R9", 32'(done_cnt), 32'h1, "done pulses per run");
    chk(ana_ctrl == 32'h000D_0FFF, "R7", ana_ctrl, 32'h000D_0FFF, "final control word");
    chk(cal_code == val, "R8", 32'(cal_code), 32'(val), "captured code");
    chk(cal_timeout == exp_tmo, "R6", 32'(cal_timeout), 32'(exp_tmo), "timeout flag");
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    us_tick = 1'b0;
    cal_done = 1'b0;
    cal_val = 6'h00;
    repeat (4) @(negedge clk);
    chk(ana_ctrl == 32'h0, "R1", ana_ctrl, 32'h0, "ctrl in reset");
    chk(cal_code == 6'h0, "R1", 32'(cal_code), 32'h0, "code in reset");
    chk(seq_done == 1'b0, "R1", 32'(seq_done), 32'h0, "done in reset");
    chk(cal_timeout == 1'b0, "R1", 32'(cal_timeout), 32'h0, "timeout in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1;

    // ticks every cycle, flag rises mid-poll, extra starts while busy
    run_seq(1, 50, 6'h2A, 1'b1, 1'b0);
    // R10: sparse ticks, flag already high so the first polled tick ends the poll (R5)
    tag_pfx = "R10 ";
    run_seq(3, 0, 6'h15, 1'b0, 1'b0);
    tag_pfx = "";
    // flag never rises: timeout after 2000 polled ticks
    run_seq(1, -1, 6'h3F, 1'b1, 1'b1);
    // next start clears the timeout flag
    run_seq(2, 7, 6'h01, 1'b0, 1'b0);

    if (wd_hit) begin
      n_bad++;
      $display("FAIL R8 watchdog expired act=%0d exp=<150000", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule